// File: doc/BRIEF.md
# Static Memory Strobe Timing Controller

This block sequences read and write accesses to external asynchronous static memories such as SRAM, NOR flash or display modules. Four chip-select regions each carry their own timing set. The set holds a setup count and a pulse count for four strobes: write enable, chip select in a write, output enable, and chip select in a read. It also holds a total cycle length for each direction, and two mode bits. Every count is in system clock cycles, and the hold time is whatever is left of the cycle after setup and pulse.

A requester hands over address, write data, direction and region index on a valid/ready channel. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` falls on that edge and rises again in the cycle that carries `rsp_done`, so the requester may keep `req_valid` high across an access and the next request is taken at the end of the done cycle. The response has no back-pressure: `rsp_done` is a single-cycle pulse, and `rsp_rdata` holds the last read word until the next read overwrites it.

A timing set that cannot be met is refused at the handshake. Such a request produces no strobes and no done pulse, and it sets a sticky error flag that only reset clears.

Top module: `asram_timing_ctrl`

## Requirements
- R1: The timing-set input holds one 72-bit region per chip select, and region n sits at bits [72n+71:72n]. The fields from bit 0 upward are: write-strobe setup [5:0], write chip-select setup [11:6], read-strobe setup [17:12], read chip-select setup [23:18], then write-strobe pulse [30:24], write chip-select pulse [37:31], read-strobe pulse [44:38], read chip-select pulse [51:45], then write cycle [60:52], read cycle [69:61], write-by-chip-select [70] and read-by-chip-select [71]. An access uses the region named by `req_cs` on the accepting edge.
- R2: A 6-bit setup field counts 128·b5 + b[4:0] cycles, and zero is allowed. A 7-bit pulse field counts 256·b6 + b[5:0] cycles. A 9-bit cycle field counts 256·b[8:7] + b[6:0] cycles.
- R3: Cycle 0 is the cycle after the accepting edge. A strobe with setup S and pulse P is low in cycles S through S+P-1 and high at all other times. All strobes are active-low.
- R4: Only the chip-select line of the addressed region goes low. It uses the chip-select timing of the access direction, and every other chip-select line stays high.
- R5: When write-by-chip-select is 0, `mem_we_n` pulses with the write-strobe timing. When it is 1, `mem_we_n` stays high for the whole write and the chip-select line qualifies the write.
- R6: On a write, `mem_dq_oe` is high from the setup of the qualifying write signal to the end of the cycle, and `mem_dq_o` equals the request's write data. `mem_dq_oe` is never high on a read.
- R7: On a read, the read-by-chip-select bit picks the qualifying signal: output enable when 0 (and then `mem_oe_n` pulses), chip select when 1 (and then `mem_oe_n` stays high). `rsp_rdata` takes `mem_dq_i` as it stands in the last pulse cycle of the qualifying signal.
- R8: For a cycle length C, `rsp_done` is high for exactly cycle C. `req_ready` is low in cycles 0 through C-1 and high in cycle C, so a held request is accepted at the end of the done cycle.
- R9: An access is refused when either signal of its direction has a zero pulse, or when the cycle length is shorter than that signal's setup plus pulse. A refused access sets `cfg_err`, drives no strobe and raises no done. `cfg_err` then stays high until reset.
- R10: After reset, `req_ready` is high, all strobes are high, and `mem_dq_oe`, `rsp_done` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_i | input | NUM_CS*72 | Timing sets of all regions |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 write, 0 read |
| req_cs | input | CS_W | Region index |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle end-of-access pulse |
| rsp_rdata | output | DATA_W | Last word read |
| cfg_err | output | 1 | Sticky illegal-timing flag |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | NUM_CS | Chip selects, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_dq_o | output | DATA_W | Data bus output value |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | DATA_W | Data bus input value |

## Verification
Accesses are run with small counts, with zero setups, with a one-cycle total length, and with the offset bits set in setup, pulse and cycle fields. These patterns separate the field decoding from the plain low bits, and they expose off-by-one errors at the window edges. Each direction is tried with both qualifier modes, which shows whether the strobe is silenced and whether the data window and the read sample point follow the chip-select timing. The read bus carries the current cycle number, so the captured word identifies the exact cycle in which it was sampled. Each access lands in a different region while the other regions hold a distinct timing, which catches a wrong region select. Directed cases cover a request held across back-to-back accesses, both kinds of refused timing set, and whether the error flag stays set and is cleared by reset.

// File: rtl/asram_pkg.sv
package asram_pkg;
  localparam int CNT_W = 10;
  localparam int CFG_W = 72;
  localparam int NSIG  = 4;
  localparam int SIG_WE  = 0;
  localparam int SIG_CSW = 1;
  localparam int SIG_OE  = 2;
  localparam int SIG_CSR = 3;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic       rd_by_cs;
    logic       wr_by_cs;
    logic [8:0] rd_cycle;
    logic [8:0] wr_cycle;
    logic [6:0] csrd_pulse;
    logic [6:0] oe_pulse;
    logic [6:0] cswr_pulse;
    logic [6:0] we_pulse;
    logic [5:0] csrd_setup;
    logic [5:0] oe_setup;
    logic [5:0] cswr_setup;
    logic [5:0] we_setup;
  } region_cfg_t;

  function automatic cnt_t dec_setup(input logic [5:0] c);
    return {2'b00, c[5], 2'b00, c[4:0]};
  endfunction

  function automatic cnt_t dec_pulse(input logic [6:0] c);
    return {1'b0, c[6], 2'b00, c[5:0]};
  endfunction

  function automatic cnt_t dec_cycle(input logic [8:0] c);
    return {c[8:7], 1'b0, c[6:0]};
  endfunction
endpackage

// File: rtl/region_cfg_decode.sv
module region_cfg_decode
  import asram_pkg::*;
(
  input  region_cfg_t cfg,
  input  logic        is_write,
  output cnt_t        setup_o [NSIG],
  output cnt_t        pulse_o [NSIG],
  output cnt_t        cycle_o,
  output logic        by_cs_o,
  output logic        bad_o
);
  cnt_t sig_s [NSIG];
  cnt_t sig_p [NSIG];
  int   a_idx, b_idx;

  always_comb begin
    sig_s[SIG_WE]  = dec_setup(cfg.we_setup);
    sig_s[SIG_CSW] = dec_setup(cfg.cswr_setup);
    sig_s[SIG_OE]  = dec_setup(cfg.oe_setup);
    sig_s[SIG_CSR] = dec_setup(cfg.csrd_setup);
    sig_p[SIG_WE]  = dec_pulse(cfg.we_pulse);
    sig_p[SIG_CSW] = dec_pulse(cfg.cswr_pulse);
    sig_p[SIG_OE]  = dec_pulse(cfg.oe_pulse);
    sig_p[SIG_CSR] = dec_pulse(cfg.csrd_pulse);
    cycle_o = is_write ? dec_cycle(cfg.wr_cycle) : dec_cycle(cfg.rd_cycle);
    by_cs_o = is_write ? cfg.wr_by_cs : cfg.rd_by_cs;
    a_idx   = is_write ? SIG_WE  : SIG_OE;
    b_idx   = is_write ? SIG_CSW : SIG_CSR;
    bad_o   = (sig_p[a_idx] == '0) || (sig_p[b_idx] == '0) ||
              (cycle_o < sig_s[a_idx] + sig_p[a_idx]) ||
              (cycle_o < sig_s[b_idx] + sig_p[b_idx]);
    for (int i = 0; i < NSIG; i++) begin
      setup_o[i] = sig_s[i];
      pulse_o[i] = sig_p[i];
    end
  end
endmodule

// File: rtl/strobe_window.sv
module strobe_window
  import asram_pkg::*;
(
  input  cnt_t cnt,
  input  cnt_t setup,
  input  cnt_t pulse,
  input  logic en,
  output logic act,
  output logic last
);
  cnt_t edge_end;
  assign edge_end = setup + pulse;
  assign act  = en && (cnt >= setup) && (cnt < edge_end);
  assign last = en && (cnt == edge_end - cnt_t'(1));
endmodule

// File: rtl/access_seq.sv
module access_seq
  import asram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  cnt_t cyc_len,
  output logic busy,
  output cnt_t cnt,
  output logic done
);
  logic at_end;
  assign at_end = busy && (cnt == cyc_len - cnt_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= at_end;
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (at_end) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + cnt_t'(1);
      end
    end
  end

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < cyc_len);
endmodule

// File: rtl/asram_timing_ctrl.sv
module asram_timing_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int NUM_CS = 4,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CS*CFG_W-1:0] cfg_i,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [CS_W-1:0]         req_cs,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rsp_done,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic                    cfg_err,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [NUM_CS-1:0]       mem_cs_n,
  output logic                    mem_we_n,
  output logic                    mem_oe_n,
  output logic [DATA_W-1:0]       mem_dq_o,
  output logic                    mem_dq_oe,
  input  logic [DATA_W-1:0]       mem_dq_i
);
  region_cfg_t regions [NUM_CS];
  region_cfg_t sel_cfg;
  cnt_t        d_setup [NSIG];
  cnt_t        d_pulse [NSIG];
  cnt_t        d_cycle;
  logic        d_by_cs, d_bad;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_region
    assign regions[g] = cfg_i[g*CFG_W +: CFG_W];
  end
  assign sel_cfg = regions[req_cs];

  region_cfg_decode u_dec (
    .cfg(sel_cfg), .is_write(req_write),
    .setup_o(d_setup), .pulse_o(d_pulse), .cycle_o(d_cycle),
    .by_cs_o(d_by_cs), .bad_o(d_bad)
  );

  logic accept, start, busy;
  cnt_t cnt;
  assign accept    = req_valid && req_ready;
  assign start     = accept && !d_bad;
  assign req_ready = !busy;

  cnt_t            setup_q [NSIG];
  cnt_t            pulse_q [NSIG];
  cnt_t            cyc_q;
  logic            wr_q, by_cs_q;
  logic [CS_W-1:0] cs_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q    <= cnt_t'(1);
      wr_q     <= 1'b0;
      by_cs_q  <= 1'b0;
      cs_q     <= '0;
      wdata_q  <= '0;
      mem_addr <= '0;
      cfg_err  <= 1'b0;
      for (int i = 0; i < NSIG; i++) begin
        setup_q[i] <= '0;
        pulse_q[i] <= cnt_t'(1);
      end
    end else begin
      if (accept && d_bad) cfg_err <= 1'b1;
      if (start) begin
        cyc_q    <= d_cycle;
        wr_q     <= req_write;
        by_cs_q  <= d_by_cs;
        cs_q     <= req_cs;
        wdata_q  <= req_wdata;
        mem_addr <= req_addr;
        for (int i = 0; i < NSIG; i++) begin
          setup_q[i] <= d_setup[i];
          pulse_q[i] <= d_pulse[i];
        end
      end
    end
  end

  access_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cyc_len(cyc_q),
    .busy(busy), .cnt(cnt), .done(rsp_done)
  );

  logic [NSIG-1:0] act, last;
  for (genvar s = 0; s < NSIG; s++) begin : g_win
    localparam bit FOR_WRITE = (s == SIG_WE) || (s == SIG_CSW);
    strobe_window u_win (
      .cnt(cnt), .setup(setup_q[s]), .pulse(pulse_q[s]),
      .en(busy && (wr_q == FOR_WRITE)),
      .act(act[s]), .last(last[s])
    );
  end

  logic cs_act;
  assign cs_act   = act[SIG_CSW] || act[SIG_CSR];
  assign mem_we_n = !(act[SIG_WE] && !by_cs_q);
  assign mem_oe_n = !(act[SIG_OE] && !by_cs_q);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_csn
    assign mem_cs_n[g] = !(cs_act && (cs_q == CS_W'(g)));
  end

  cnt_t wq_setup;
  assign wq_setup  = by_cs_q ? setup_q[SIG_CSW] : setup_q[SIG_WE];
  assign mem_dq_oe = busy && wr_q && (cnt >= wq_setup);
  assign mem_dq_o  = wdata_q;

  logic rd_take;
  assign rd_take = by_cs_q ? last[SIG_CSR] : last[SIG_OE];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rsp_rdata <= '0;
    else if (rd_take) rsp_rdata <= mem_dq_i;
  end

  // R4
  one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  // R6
  dq_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (busy && wr_q));
  // R5
  we_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_q && by_cs_q) |-> mem_we_n);
  // R3
  idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_we_n && mem_oe_n && (&mem_cs_n)));
  // R8
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);
endmodule

// File: tb/sim_asram_timing_ctrl.sv
module sim_asram_timing_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       wr;
    logic [1:0] cs;
    logic [5:0] ss;
    logic [6:0] sp;
    logic [5:0] css;
    logic [6:0] csp;
    logic [8:0] cyc;
    logic       bycs;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 6'd1,  7'd6,  6'd0,  7'd8,  9'd10,  1'b0},
    '{1'b0, 2'd1, 6'd2,  7'd3,  6'd1,  7'd5,  9'd7,   1'b0},
    '{1'b1, 2'd2, 6'd0,  7'd1,  6'd0,  7'd1,  9'd1,   1'b1},
    '{1'b0, 2'd3, 6'd3,  7'd2,  6'd1,  7'd6,  9'd9,   1'b1},
    '{1'b1, 2'd3, 6'h21, 7'h41, 6'h20, 7'h42, 9'h182, 1'b0},
    '{1'b0, 2'd0, 6'h20, 7'h40, 6'd0,  7'd5,  9'h100, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [287:0] cfg_i = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_cs = '0;
  logic [15:0] req_addr = '0, req_wdata = '0, mem_dq_i = '0;
  logic req_ready, rsp_done, cfg_err, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_o;
  logic [3:0] mem_cs_n;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asram_timing_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .cfg_err(cfg_err),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int e_set(input logic [5:0] c);
    return (c[5] ? 128 : 0) + int'(c[4:0]);
  endfunction
  function automatic int e_pul(input logic [6:0] c);
    return (c[6] ? 256 : 0) + int'(c[5:0]);
  endfunction
  function automatic int e_cyc(input logic [8:0] c);
    return 256 * int'(c[8:7]) + int'(c[6:0]);
  endfunction

  function automatic logic [71:0] mk_region(input logic [5:0] ss, input logic [6:0] sp,
      input logic [5:0] css, input logic [6:0] csp, input logic [8:0] cyc, input logic bycs);
    return {bycs, bycs, cyc, cyc, csp, sp, csp, sp, css, ss, css, ss};
  endfunction

  task automatic load_cfg(input int region, input logic [71:0] r);
    for (int i = 0; i < 4; i++)
      cfg_i[i*72 +: 72] = (i == region) ? r : mk_region(6'd2, 7'd4, 6'd2, 7'd4, 9'd12, 1'b0);
  endtask

  task automatic run_vec(input int idx);
    vec_t v = VECS[idx];
    int C = e_cyc(v.cyc);
    int s = e_set(v.ss), p = e_pul(v.sp), cs_s = e_set(v.css), cs_p = e_pul(v.csp);
    int we_f = -1, we_c = 0, oe_f = -1, oe_c = 0, cs_f = -1, cs_c = 0, other = 0;
    int dq_f = -1, dq_c = 0, dq_bad = 0, rdy_bad = 0, done_k = -1;
    int qs, qp, exp_dq_f;
    logic [15:0] addr = 16'h3A00 + 16'(idx * 16'h0111);
    load_cfg(v.cs, mk_region(v.ss, v.sp, v.css, v.csp, v.cyc, v.bycs));
    @(negedge clk);
    req_valid = 1'b1; req_write = v.wr; req_cs = v.cs;
    req_addr = addr; req_wdata = ~addr;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k <= C + 2; k++) begin
      mem_dq_i = {addr[7:0], 8'(k)};
      if (!mem_we_n) begin if (we_f < 0) we_f = k; we_c++; end
      if (!mem_oe_n) begin if (oe_f < 0) oe_f = k; oe_c++; end
      if (!mem_cs_n[v.cs]) begin if (cs_f < 0) cs_f = k; cs_c++; end
      for (int j = 0; j < 4; j++) if (j != int'(v.cs) && !mem_cs_n[j]) other++;
      if (mem_dq_oe) begin
        if (dq_f < 0) dq_f = k;
        dq_c++;
        if (mem_dq_o !== ~addr) dq_bad++;
      end
      if (k < C && req_ready) rdy_bad++;
      if (rsp_done) begin
        done_k = k;
        break;
      end
      @(negedge clk);
    end
    chk(done_k == C, "R8 done cycle", done_k, C);
    chk(rdy_bad == 0, "R8 ready low while busy", rdy_bad, 0);
    chk(mem_addr == addr, "R1 address held", int'(mem_addr), int'(addr));
    chk(cs_f == cs_s && cs_c == cs_p, "R4 chip select window start", cs_f, cs_s);
    chk(cs_c == cs_p, "R3 chip select window length", cs_c, cs_p);
    chk(other == 0, "R4 other regions idle", other, 0);
    if (v.wr) begin
      chk(oe_c == 0, "R6 no read strobe on write", oe_c, 0);
      if (v.bycs) chk(we_c == 0, "R5 write strobe quiet", we_c, 0);
      else chk(we_f == s && we_c == p, "R3 R2 write strobe window", we_f * 1000 + we_c, s * 1000 + p);
      exp_dq_f = v.bycs ? cs_s : s;
      chk(dq_f == exp_dq_f && dq_c == C - exp_dq_f, "R6 data drive window",
          dq_f * 1000 + dq_c, exp_dq_f * 1000 + C - exp_dq_f);
      chk(dq_bad == 0, "R6 write data value", dq_bad, 0);
    end else begin
      chk(we_c == 0 && dq_c == 0, "R6 no drive on read", we_c + dq_c, 0);
      if (v.bycs) chk(oe_c == 0, "R7 read strobe quiet", oe_c, 0);
      else chk(oe_f == s && oe_c == p, "R3 R2 read strobe window", oe_f * 1000 + oe_c, s * 1000 + p);
      qs = v.bycs ? cs_s : s;
      qp = v.bycs ? cs_p : p;
      chk(rsp_rdata == {addr[7:0], 8'(qs + qp - 1)}, "R7 read sample point",
          int'(rsp_rdata), int'({addr[7:0], 8'(qs + qp - 1)}));
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int dk [2];
    int nd;
    load_cfg(0, mk_region(6'd1, 7'd2, 6'd0, 7'd3, 9'd4, 1'b0));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(req_ready && mem_we_n && mem_oe_n && mem_cs_n == 4'hF && !mem_dq_oe
        && !rsp_done && !cfg_err, "R10 reset state", 0, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !cfg_err && mem_cs_n == 4'hF, "R10 after release", 0, 1);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R8 held request: two back-to-back accesses with C=1
    load_cfg(2, mk_region(6'd0, 7'd1, 6'd0, 7'd1, 9'd1, 1'b1));
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_cs = 2'd2; req_wdata = 16'h55AA;
    nd = 0;
    @(negedge clk);
    for (int k = 0; k < 7; k++) begin
      if (rsp_done) begin
        if (nd < 2) dk[nd] = k;
        nd++;
      end
      if (k == 3) req_valid = 1'b0;
      @(negedge clk);
    end
    chk(nd == 2, "R8 held request done count", nd, 2);
    chk(dk[0] == 1 && dk[1] == 3, "R8 held request accepted in done cycle",
        dk[0] * 10 + dk[1], 13);

    // R9 zero pulse refused
    load_cfg(1, mk_region(6'd1, 7'd0, 6'd0, 7'd3, 9'd8, 1'b0));
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_cs = 2'd1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(cfg_err == 1'b1, "R9 zero pulse flags error", int'(cfg_err), 1);
    nd = 0;
    for (int k = 0; k < 6; k++) begin
      if (rsp_done || !mem_we_n || mem_cs_n != 4'hF || !req_ready) nd++;
      @(negedge clk);
    end
    chk(nd == 0, "R9 refused access is silent", nd, 0);
    run_vec(1);
    chk(cfg_err == 1'b1, "R9 error stays set", int'(cfg_err), 1);

    // R10 reset clears, then R9 short cycle refused
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_err == 1'b0, "R10 reset clears error", int'(cfg_err), 0);
    load_cfg(3, mk_region(6'd3, 7'd4, 6'd0, 7'd2, 9'd6, 1'b0));
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_cs = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    chk(cfg_err == 1'b1, "R9 short cycle flags error", int'(cfg_err), 1);
    @(negedge clk);
    chk(mem_oe_n && mem_cs_n == 4'hF && !rsp_done, "R9 short cycle no strobes", 0, 1);

    finish_run();
  end
endmodule